// File: doc/BRIEF.md
# Quadrature Position Decoder with Selectable Edge Resolution

This block turns the two phase-shifted square waves of an incremental shaft encoder into a signed position count. The two channel inputs must already be synchronised to `clk`. The block looks at them only in cycles where `sample_en` is high, so that strobe sets the sample rate. Each sample is compared with the one before it. When a transition is accepted, the block moves the count by one, raises `step_pulse` for one cycle and shows the direction on `step_up`. A rate-measurement stage further down the chain can time these pulses.

The `mode` input selects the resolution at run time:
- 4x: every edge on either channel is counted.
- 2x: both edges of channel A are counted.
- 1x: only the rising edge of channel A is counted, and the level of channel B at that sample still gives the direction.

The tracker runs as a state machine with five states. `PH_UNSEEN` is the state after reset, before any sample has been taken. The other four states are the sampled phases `PH_00`, `PH_10`, `PH_11` and `PH_01`, named as {A,B}. Each sample produces one of four moves:
- `MV_HOLD`: the phase is unchanged.
- `MV_FWD`: one step along 00→10→11→01→00.
- `MV_BACK`: one step along the reverse ring.
- `MV_BAD`: both channels changed at once.

Whatever the move, the tracker then takes the newly sampled phase as its state. A bad move is never counted; it raises `err_pulse` instead.

Top module: `quad_decoder`

## Requirements
- R1: In reset the count is zero and `step_pulse`, `step_up` and `err_pulse` are low. The first sample after reset only loads the phase: it produces no count and no error, whatever the channel levels are.
- R2: The channels are looked at only in cycles with `sample_en` high. The results (count, strobe, error) appear on the clock edge that takes the sample. In cycles without a sample both pulses are low and the count holds, however the channels move between samples.
- R3: Mode 2'b10 (4x) counts every single-channel change. A step forward along the {A,B} ring 00→10→11→01→00 adds one with `step_up`=1. A step backward subtracts one with `step_up`=0.
- R4: Mode 2'b01 (2x) counts only samples in which A changed. It adds one for A rising with B=0 or A falling with B=1, and subtracts one for the other two cases.
- R5: Mode 2'b00 (1x) counts only samples in which A rose. It adds one when B=0 and subtracts one when B=1.
- R6: Mode 2'b11 behaves exactly like 4x.
- R7: A sample in which both A and B differ from the previous sample gives a one-cycle `err_pulse` and no count or strobe. The sampled levels become the new reference phase.
- R8: In 1x and 2x, B-only changes do not alter the count and give no strobe. In 1x, A falling also gives no count and no strobe.
- R9: `step_pulse` lasts one cycle per counted edge. `step_up` gives that edge's direction and holds its value until the next counted edge.
- R10: The count is a COUNT_W-bit two's-complement value that wraps from the maximum to the minimum and from the minimum to the maximum.
- R11: `clear` zeroes the count on the next edge without raising `err_pulse`. If a counted edge is taken in the same cycle, the count still becomes zero, while `step_pulse` and `step_up` report that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_en | input | 1 | Sample strobe; channels are looked at only when high |
| ch_a | input | 1 | Channel A, already synchronised |
| ch_b | input | 1 | Channel B, already synchronised |
| mode | input | 2 | 00 = 1x, 01 = 2x, 10 or 11 = 4x |
| clear | input | 1 | Synchronous count clear |
| count | output | COUNT_W | Signed position count |
| step_pulse | output | 1 | One-cycle strobe per counted edge |
| step_up | output | 1 | Direction of the last counted edge (1 = increment) |
| err_pulse | output | 1 | One-cycle strobe for a sample where both channels changed |

## Verification
The bench builds the decoder with COUNT_W = 8 so that both wrap points, +127 to −128 and −128 to +127, can be reached within a few hundred edges. With the default 32-bit width they would be far out of reach. A behavioural model tracks ring positions as integers and compares every output on every clock. It covers walks in all four mode codes, channel glitches between samples, both kinds of double change, and a clear that lands on a counted edge.

// File: rtl/qdec_pkg.sv
package qdec_pkg;

    typedef enum logic [2:0] {
        PH_UNSEEN,
        PH_00,
        PH_10,
        PH_11,
        PH_01
    } phase_e;

    typedef enum logic [1:0] {
        MODE_X1  = 2'b00,
        MODE_X2  = 2'b01,
        MODE_X4  = 2'b10,
        MODE_X4B = 2'b11
    } mode_e;

    typedef enum logic [1:0] {
        MV_HOLD,
        MV_FWD,
        MV_BACK,
        MV_BAD
    } move_e;

    typedef struct packed {
        move_e move;
        logic  a_edge;
        logic  a_level;
    } step_info_t;

    function automatic phase_e phase_of(input logic a, input logic b);
        phase_e p;
        unique case ({a, b})
            2'b00:   p = PH_00;
            2'b10:   p = PH_10;
            2'b11:   p = PH_11;
            default: p = PH_01;
        endcase
        return p;
    endfunction

    function automatic logic a_of(input phase_e p);
        return (p == PH_10) || (p == PH_11);
    endfunction

endpackage

// File: rtl/qdec_phase_tracker.sv
module qdec_phase_tracker
    import qdec_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sample_en,
    input  logic       ch_a,
    input  logic       ch_b,
    output step_info_t info
);

    phase_e cur_q;
    phase_e nxt;
    phase_e seen;

    assign seen = phase_of(ch_a, ch_b);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= PH_UNSEEN;
        end else begin
            cur_q <= nxt;
        end
    end

    // next state and move classification
    always_comb begin
        nxt          = cur_q;
        info.move    = MV_HOLD;
        info.a_edge  = 1'b0;
        info.a_level = ch_a;
        if (sample_en) begin
            nxt = seen;
            unique case (cur_q)
                PH_UNSEEN: begin
                    info.move = MV_HOLD;
                end
                PH_00: begin
                    case (seen)
                        PH_10:   info.move = MV_FWD;
                        PH_01:   info.move = MV_BACK;
                        PH_11:   info.move = MV_BAD;
                        default: info.move = MV_HOLD;
                    endcase
                end
                PH_10: begin
                    case (seen)
                        PH_11:   info.move = MV_FWD;
                        PH_00:   info.move = MV_BACK;
                        PH_01:   info.move = MV_BAD;
                        default: info.move = MV_HOLD;
                    endcase
                end
                PH_11: begin
                    case (seen)
                        PH_01:   info.move = MV_FWD;
                        PH_10:   info.move = MV_BACK;
                        PH_00:   info.move = MV_BAD;
                        default: info.move = MV_HOLD;
                    endcase
                end
                PH_01: begin
                    case (seen)
                        PH_00:   info.move = MV_FWD;
                        PH_11:   info.move = MV_BACK;
                        PH_10:   info.move = MV_BAD;
                        default: info.move = MV_HOLD;
                    endcase
                end
                default: begin
                    info.move = MV_HOLD;
                end
            endcase
            if (cur_q != PH_UNSEEN) begin
                info.a_edge = (a_of(cur_q) != ch_a);
            end
        end
    end

endmodule

// File: rtl/qdec_mode_gate.sv
module qdec_mode_gate
    import qdec_pkg::*;
(
    input  mode_e      mode,
    input  step_info_t info,
    output logic       count_en,
    output logic       count_up,
    output logic       bad
);

    logic legal_step;

    assign legal_step = (info.move == MV_FWD) || (info.move == MV_BACK);
    assign bad        = (info.move == MV_BAD);
    assign count_up   = (info.move == MV_FWD);

    always_comb begin
        unique case (mode)
            MODE_X1:  count_en = legal_step && info.a_edge && info.a_level;
            MODE_X2:  count_en = legal_step && info.a_edge;
            MODE_X4,
            MODE_X4B: count_en = legal_step;
            default:  count_en = 1'b0;
        endcase
    end

endmodule

// File: rtl/qdec_position.sv
module qdec_position #(
    parameter int COUNT_W = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      count_en,
    input  logic                      count_up,
    input  logic                      bad,
    input  logic                      clear,
    output logic signed [COUNT_W-1:0] count,
    output logic                      step_pulse,
    output logic                      step_up,
    output logic                      err_pulse
);

    localparam logic [COUNT_W-1:0] STEP_ONE = COUNT_W'(1);

    logic [COUNT_W-1:0] cnt_q;
    logic [COUNT_W-1:0] cnt_d;

    always_comb begin
        cnt_d = cnt_q;
        if (clear) begin
            cnt_d = '0;
        end else if (count_en) begin
            cnt_d = count_up ? (cnt_q + STEP_ONE) : (cnt_q - STEP_ONE);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q      <= '0;
            step_pulse <= 1'b0;
            step_up    <= 1'b0;
            err_pulse  <= 1'b0;
        end else begin
            cnt_q      <= cnt_d;
            step_pulse <= count_en;
            err_pulse  <= bad;
            if (count_en) begin
                step_up <= count_up;
            end
        end
    end

    assign count = $signed(cnt_q);

endmodule

// File: rtl/quad_decoder.sv
module quad_decoder
    import qdec_pkg::*;
#(
    parameter int COUNT_W = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      sample_en,
    input  logic                      ch_a,
    input  logic                      ch_b,
    input  logic [1:0]                mode,
    input  logic                      clear,
    output logic signed [COUNT_W-1:0] count,
    output logic                      step_pulse,
    output logic                      step_up,
    output logic                      err_pulse
);

    step_info_t info;
    logic       count_en;
    logic       count_up;
    logic       bad;

    qdec_phase_tracker u_track (
        .clk       (clk),
        .rst_n     (rst_n),
        .sample_en (sample_en),
        .ch_a      (ch_a),
        .ch_b      (ch_b),
        .info      (info)
    );

    qdec_mode_gate u_gate (
        .mode     (mode_e'(mode)),
        .info     (info),
        .count_en (count_en),
        .count_up (count_up),
        .bad      (bad)
    );

    qdec_position #(.COUNT_W(COUNT_W)) u_pos (
        .clk        (clk),
        .rst_n      (rst_n),
        .count_en   (count_en),
        .count_up   (count_up),
        .bad        (bad),
        .clear      (clear),
        .count      (count),
        .step_pulse (step_pulse),
        .step_up    (step_up),
        .err_pulse  (err_pulse)
    );

endmodule

// File: rtl/qdec_checker.sv
module qdec_checker #(
    parameter int COUNT_W = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic               sample_en,
    input logic               ch_a,
    input logic               ch_b,
    input logic [1:0]         mode,
    input logic               clear,
    input logic [COUNT_W-1:0] count,
    input logic               step_pulse,
    input logic               step_up,
    input logic               err_pulse
);

    localparam logic [COUNT_W-1:0] ONE = COUNT_W'(1);

    logic past_ok;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    // R2: pulses only follow a sample cycle
    assert_pulse_needs_sample_R2: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
        (step_pulse || err_pulse) |-> $past(sample_en));

    // R2: count holds when nothing was counted or cleared
    assert_count_holds_R2: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
        (!step_pulse && !$past(clear)) |-> (count == $past(count)));

    // R7: a bad sample never counts
    assert_err_no_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(err_pulse && step_pulse));

    // R10: each counted edge moves the count by exactly one, wrapping
    assert_unit_step_R10: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
        (step_pulse && !$past(clear)) |->
            (count == (step_up ? ($past(count) + ONE) : ($past(count) - ONE))));

    // R11: clear lands as zero
    assert_clear_zero_R11: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
        $past(clear) |-> (count == '0));

    // R5: 1x counts only on A high with direction from B
    assert_x1_dir_R5: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
        (step_pulse && $past(mode) == 2'b00) |-> ($past(ch_a) && (step_up == !$past(ch_b))));

    // R4: 2x direction is the exclusive-or of the sampled levels
    assert_x2_dir_R4: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
        (step_pulse && $past(mode) == 2'b01) |-> (step_up == ($past(ch_a) ^ $past(ch_b))));

    // R9: direction only changes with a strobe
    assert_dir_stable_R9: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
        !step_pulse |-> $stable(step_up));

endmodule

bind quad_decoder qdec_checker #(.COUNT_W(COUNT_W)) u_qdec_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sample_en  (sample_en),
    .ch_a       (ch_a),
    .ch_b       (ch_b),
    .mode       (mode),
    .clear      (clear),
    .count      (count),
    .step_pulse (step_pulse),
    .step_up    (step_up),
    .err_pulse  (err_pulse)
);

// File: tb/quad_decoder_tb_top.sv
`timescale 1ns/1ps
module quad_decoder_tb_top;

    localparam int W = 8;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                sample_en = 1'b0;
    logic                ch_a = 1'b0;
    logic                ch_b = 1'b0;
    logic [1:0]          mode = 2'b10;
    logic                clear = 1'b0;
    logic signed [W-1:0] count;
    logic                step_pulse;
    logic                step_up;
    logic                err_pulse;

    always #10 clk = ~clk;

    quad_decoder #(.COUNT_W(W)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .sample_en  (sample_en),
        .ch_a       (ch_a),
        .ch_b       (ch_b),
        .mode       (mode),
        .clear      (clear),
        .count      (count),
        .step_pulse (step_pulse),
        .step_up    (step_up),
        .err_pulse  (err_pulse)
    );

    int    n_cmp = 0;
    int    n_bad = 0;
    bit    done = 0;
    string cur_req = "R1";

    // behavioural reference
    int m_cnt;
    bit m_primed;
    int m_prev;
    bit m_prev_a;
    bit e_step, e_up, e_err;
    int pos;
    bit ring_a [4] = '{0, 1, 1, 0};
    bit ring_b [4] = '{0, 0, 1, 1};

    function automatic int ringpos(bit a, bit b);
        if (!a && !b) return 0;
        if (a && !b)  return 1;
        if (a && b)   return 2;
        return 3;
    endfunction

    task automatic model_reset();
        m_cnt = 0; m_primed = 0; m_prev = 0; m_prev_a = 0;
        e_step = 0; e_up = 0; e_err = 0;
    endtask

    task automatic model_step(bit a, bit b, bit en, bit [1:0] md, bit clr);
        e_step = 0;
        e_err  = 0;
        if (en) begin
            if (!m_primed) begin
                m_primed = 1;
            end else begin
                int d;
                bit a_chg, take;
                d = (ringpos(a, b) - m_prev + 4) % 4;
                a_chg = (a != m_prev_a);
                take = 0;
                if (d == 2) e_err = 1;
                else if (d != 0) begin
                    if (md == 2'b00)      take = a_chg && a;
                    else if (md == 2'b01) take = a_chg;
                    else                  take = 1;
                    if (take) begin
                        e_step = 1;
                        e_up   = (d == 1);
                        m_cnt  = m_cnt + ((d == 1) ? 1 : -1);
                    end
                end
            end
            m_prev   = ringpos(a, b);
            m_prev_a = a;
        end
        if (clr) m_cnt = 0;
        m_cnt = ((m_cnt % 256) + 256) % 256;
    endtask

    task automatic check_bit(string what, bit got, bit exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got %0d expected %0d", cur_req, what, got, exp);
        end
    endtask

    task automatic compare_all();
        n_cmp++;
        if ($unsigned(count) !== m_cnt[W-1:0]) begin
            n_bad++;
            $display("FAIL %s count: got %0d expected %0d", cur_req, $unsigned(count), m_cnt);
        end
        check_bit("step_pulse", step_pulse, e_step);
        check_bit("step_up", step_up, e_up);
        check_bit("err_pulse", err_pulse, e_err);
    endtask

    task automatic tick(bit a, bit b, bit en, bit [1:0] md, bit clr);
        @(negedge clk);
        compare_all();
        ch_a = a; ch_b = b; sample_en = en; mode = md; clear = clr;
        model_step(a, b, en, md, clr);
    endtask

    // one ring step plus an idle cycle with glitching channels
    task automatic walk(int n, bit fwd, bit [1:0] md);
        for (int i = 0; i < n; i++) begin
            pos = (pos + (fwd ? 1 : 3)) % 4;
            tick(ring_a[pos], ring_b[pos], 1, md, 0);
            tick(~ring_a[pos], ring_b[pos] ^ i[0], 0, md, 0);
        end
    endtask

    initial begin
        model_reset();
        pos = 0;
        repeat (3) @(negedge clk);
        cur_req = "R1";
        check_bit("reset step_pulse", step_pulse, 0);
        check_bit("reset err_pulse", err_pulse, 0);
        check_bit("reset step_up", step_up, 0);
        n_cmp++;
        if (count !== 0) begin
            n_bad++;
            $display("FAIL R1 reset count: got %0d expected 0", count);
        end
        rst_n = 1'b1;
        // R1: first sample at 11 only primes
        tick(1, 1, 1, 2'b10, 0);
        pos = 2;
        tick(1, 1, 0, 2'b10, 0);

        cur_req = "R3";
        walk(12, 1, 2'b10);
        walk(7, 0, 2'b10);

        cur_req = "R2";
        for (int i = 0; i < 6; i++) tick(i[0], i[1], 0, 2'b10, 0);
        tick(ring_a[pos], ring_b[pos], 1, 2'b10, 0);

        cur_req = "R4";
        walk(9, 1, 2'b01);
        walk(5, 0, 2'b01);

        cur_req = "R5";
        walk(10, 1, 2'b00);
        walk(10, 0, 2'b00);

        cur_req = "R8";
        // B-only wiggle in 1x and 2x
        for (int i = 0; i < 4; i++) begin
            tick(ring_a[pos], ~ring_b[pos], 1, i[0] ? 2'b01 : 2'b00, 0);
            tick(ring_a[pos], ring_b[pos], 1, i[0] ? 2'b01 : 2'b00, 0);
        end

        cur_req = "R6";
        walk(6, 1, 2'b11);
        walk(3, 0, 2'b11);

        cur_req = "R7";
        for (int m = 0; m < 4; m++) begin
            pos = (pos + 2) % 4;
            tick(ring_a[pos], ring_b[pos], 1, m[1:0], 0);
            tick(ring_a[pos], ring_b[pos], 0, m[1:0], 0);
            walk(2, 1, m[1:0]);
        end

        cur_req = "R9";
        walk(1, 0, 2'b10);
        for (int i = 0; i < 3; i++) tick(ring_a[pos], ring_b[pos], 1, 2'b10, 0);

        cur_req = "R11";
        tick(ring_a[pos], ring_b[pos], 0, 2'b10, 1);
        tick(ring_a[pos], ring_b[pos], 0, 2'b10, 0);
        walk(3, 1, 2'b10);
        pos = (pos + 1) % 4;
        tick(ring_a[pos], ring_b[pos], 1, 2'b10, 1);
        tick(ring_a[pos], ring_b[pos], 0, 2'b10, 0);

        cur_req = "R10";
        walk(130, 1, 2'b10);
        tick(ring_a[pos], ring_b[pos], 0, 2'b10, 1);
        walk(131, 0, 2'b10);
        walk(4, 1, 2'b10);

        @(negedge clk);
        compare_all();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog %s: got timeout expected completion", cur_req);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule